// File: doc/BRIEF.md
# Numerically Controlled Oscillator Core

This block is the digital heart of a direct digital synthesizer. A 32-bit phase register grows by a programmable step on every system clock, and its top bits address a cosine table. The result is a 10-bit offset-binary amplitude sample for a downstream converter. The output frequency is `step * f_clk / 2^32`. Useful steps lie between 0 and 2^31, which keeps the tone at or below half the clock rate.

Software writes the step and a phase-clear flag through a one-cycle register-write port. The written values go into staging copies only. A single-cycle `update` pulse moves all staged values into the active copies at once, so a frequency change and a clear take effect on the same edge.

Reset leaves the active clear flag set and its staged copy cleared. As a result, the phase stays at zero after reset until software issues the first update. A step of zero does not reset the phase: the phase holds its present value. Only the clear flag forces the phase to zero.

Top module: `nco_core`

## Requirements
- R1: While `rst` is high at a clock edge, `phase_o` becomes 0 and `amp_o` becomes mid-scale 512. The active and staged step both become 0, the active clear flag becomes 1 and the staged clear flag becomes 0.
- R2: After reset, `phase_o` stays 0 on every cycle until the first clock edge with `update` high, whatever is written meanwhile.
- R3: A write with `wr_en` high goes to staging only, and the active step and clear flag do not change without `update`. `wr_sel`=0 selects the 32-bit step. `wr_sel`=1 selects the control word, whose bit 0 is the clear flag; its bits 31..1 are ignored.
- R4: On an edge with `update` high, the active step and the active clear flag both load the staged values. A write in that same cycle lands in staging only: the update takes the values staged before that edge.
- R5: While the active clear flag is 0, `phase_o` advances each clock by the active step, modulo 2^32.
- R6: With an active step of 0 and the clear flag 0, `phase_o` keeps its present value.
- R7: While the active clear flag is 1, the phase register loads 0 on every clock. After release, the first phase value is therefore 0 and the next one equals the step.
- R8: `amp_o` equals 512 + round(511·cos(2π(p+0.5)/4096)) within ±1 LSB, where p is `phase_o[31:20]`. The value appears two clocks after that phase value is present on `phase_o`. A phase of 0 gives full scale 1023.
- R9: A step of 2^31 started from phase 0 makes `amp_o` alternate exactly between 1023 and 1. The table is rebuilt from a quarter wave by mirroring and sign flip, using phase bits 31..30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_sel | input | 1 | 0: step register, 1: control register |
| wr_data | input | 32 | Write data |
| update | input | 1 | Transfers all staged values to the active registers |
| phase_o | output | 32 | Current phase register value |
| amp_o | output | 10 | Offset-binary cosine amplitude |

## Verification
A register write and an update strobe can fall in the same cycle. The bench raises `wr_en` and `update` together with a new step. It then measures the phase increment over the next cycle, which must still equal the previously staged step. A later update alone must bring in the new step. The release of the clear flag and the change of step also share one edge. This is judged by the exact phase sequence 0, step, 2·step that follows, with the amplitude checked two cycles behind each phase.

// File: rtl/nco_core.sv
`timescale 1ns/1ps
module nco_core #(
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 12,
  parameter int AMP_W   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [PHASE_W-1:0] wr_data,
  input  logic               update,
  output logic [PHASE_W-1:0] phase_o,
  output logic [AMP_W-1:0]   amp_o
);
  localparam int QAW = LUT_AW - 2;
  localparam int QN  = 1 << QAW;
  localparam int MW  = AMP_W - 1;
  localparam int FS  = (1 << MW) - 1;
  localparam logic [AMP_W-1:0] MID = AMP_W'(1 << MW);

  function automatic int cos_mag(int i);
    longint x, x2, term, sum;
    x    = (longint'(2 * i + 1) * 64'sd3373259426) >>> LUT_AW;
    x2   = (x * x) >>> 30;
    term = 64'sd1 <<< 30;
    sum  = term;
    for (int k = 1; k < 8; k++) begin
      term = -((term * x2) >>> 30) / longint'((2 * k - 1) * (2 * k));
      sum  = sum + term;
    end
    return int'((sum * longint'(FS) + (64'sd1 <<< 29)) >>> 30);
  endfunction

  logic [PHASE_W-1:0] ftw_stg, ftw_act, acc;
  logic               clr_stg, clr_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      ftw_stg <= '0;
      ftw_act <= '0;
      clr_stg <= 1'b0;
      clr_act <= 1'b1;
    end else begin
      if (wr_en && !wr_sel) ftw_stg <= wr_data;
      if (wr_en && wr_sel)  clr_stg <= wr_data[0];
      if (update) begin
        ftw_act <= ftw_stg;
        clr_act <= clr_stg;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_act) acc <= '0;
    else                acc <= acc + ftw_act;
  end

  assign phase_o = acc;

  logic [MW-1:0]     qtab [QN];
  logic [LUT_AW-1:0] pidx;
  logic [1:0]        quad;
  logic [QAW-1:0]    ridx;

  for (genvar i = 0; i < QN; i++) begin : g_qtab
    assign qtab[i] = MW'(cos_mag(i));
  end

  assign pidx = acc[PHASE_W-1 -: LUT_AW];
  assign quad = pidx[LUT_AW-1 -: 2];
  assign ridx = quad[0] ? ~pidx[QAW-1:0] : pidx[QAW-1:0];

  logic [MW-1:0] mag_q;
  logic          neg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q <= '0;
      neg_q <= 1'b0;
      amp_o <= MID;
    end else begin
      mag_q <= qtab[ridx];
      neg_q <= quad[1] ^ quad[0];
      amp_o <= neg_q ? MID - {1'b0, mag_q} : MID + {1'b0, mag_q};
    end
  end
endmodule

// File: rtl/nco_core_chk.sv
`timescale 1ns/1ps
module nco_core_chk #(
  parameter int PHASE_W = 32,
  parameter int AMP_W   = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               update,
  input logic [PHASE_W-1:0] phase_o,
  input logic [PHASE_W-1:0] ftw_act,
  input logic [PHASE_W-1:0] ftw_stg,
  input logic               clr_act,
  input logic [AMP_W-1:0]   amp_o
);
  logic seen_upd;
  always_ff @(posedge clk) begin
    if (rst)         seen_upd <= 1'b0;
    else if (update) seen_upd <= 1'b1;
  end

  p_hold_clear_r2: assert property (@(posedge clk) disable iff (rst)
    !seen_upd |-> phase_o == '0);

  p_stage_only_r3: assert property (@(posedge clk) disable iff (rst)
    !update |=> $stable(ftw_act) && $stable(clr_act));

  p_update_load_r4: assert property (@(posedge clk) disable iff (rst)
    update |=> ftw_act == $past(ftw_stg));

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
    clr_act |=> phase_o == '0);

  p_full_scale_r8: assert property (@(posedge clk) disable iff (rst)
    phase_o == '0 |-> ##2 amp_o == {AMP_W{1'b1}});

  p_amp_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    amp_o != '0);
endmodule

bind nco_core nco_core_chk #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_chk (
  .clk(clk), .rst(rst), .update(update), .phase_o(phase_o),
  .ftw_act(ftw_act), .ftw_stg(ftw_stg), .clr_act(clr_act), .amp_o(amp_o)
);

// File: tb/tb_nco_core.sv
`timescale 1ns/1ps
module tb_nco_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        update = 1'b0;
  logic [31:0] phase_o;
  logic [9:0]  amp_o;

  int checks = 0;
  int errors = 0;

  nco_core dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .update(update), .phase_o(phase_o), .amp_o(amp_o)
  );

  always #2.5 clk = ~clk;

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_reg(bit sel, logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pulse_update;
    update = 1'b1;
    tick();
    update = 1'b0;
  endtask

  function automatic int exp_amp(logic [31:0] p);
    real a;
    a = 511.0 * $cos(6.283185307179586 * (real'(p[31:20]) + 0.5) / 4096.0);
    return 512 + ((a >= 0.0) ? $rtoi(a + 0.5) : -$rtoi(-a + 0.5));
  endfunction

  task automatic check_amp_window(int n);
    logic [31:0] p1, p2;
    int e, d;
    p2 = phase_o; tick();
    p1 = phase_o; tick();
    for (int i = 0; i < n; i++) begin
      e = exp_amp(p2);
      d = int'(amp_o) - e;
      check(d >= -1 && d <= 1, "R8", "cosine amplitude", amp_o, e);
      p2 = p1;
      p1 = phase_o;
      tick();
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) tick();
    check(phase_o == 0, "R1", "phase in reset", phase_o, 0);
    check(amp_o == 10'd512, "R1", "amp in reset", amp_o, 512);
    rst = 1'b0;
    tick();
  endtask

  task automatic t_hold_after_reset;
    write_reg(1'b0, 32'h0100_0000);
    for (int i = 0; i < 4; i++) begin
      tick();
      check(phase_o == 0, "R2", "phase held before first update", phase_o, 0);
    end
    check(amp_o == 10'd1023, "R8", "full scale at zero phase", amp_o, 1023);
  endtask

  task automatic t_first_update;
    pulse_update();
    check(phase_o == 0, "R7", "first phase after release", phase_o, 0);
    tick();
    check(phase_o == 32'h0100_0000, "R5", "one step", phase_o, 32'h0100_0000);
    tick();
    check(phase_o == 32'h0200_0000, "R5", "two steps", phase_o, 32'h0200_0000);
  endtask

  task automatic t_sweep;
    check_amp_window(300);
  endtask

  task automatic t_staging;
    logic [31:0] p, d;
    write_reg(1'b0, 32'h0200_0000);
    p = phase_o; tick(); d = phase_o - p;
    check(d == 32'h0100_0000, "R3", "staged step not active", d, 32'h0100_0000);
    write_reg(1'b1, 32'h1);
    p = phase_o; tick(); d = phase_o - p;
    check(d == 32'h0100_0000, "R3", "staged clear not active", d, 32'h0100_0000);
  endtask

  task automatic t_clear;
    pulse_update();
    for (int i = 0; i < 4; i++) begin
      tick();
      check(phase_o == 0, "R7", "phase forced to zero", phase_o, 0);
    end
    check(amp_o == 10'd1023, "R8", "full scale while cleared", amp_o, 1023);
    write_reg(1'b1, 32'hFFFF_FFFE);
    tick();
    check(phase_o == 0, "R3", "upper control bits ignored, still cleared", phase_o, 0);
    pulse_update();
    check(phase_o == 0, "R7", "zero on release edge", phase_o, 0);
    tick();
    check(phase_o == 32'h0200_0000, "R4", "step loaded with clear", phase_o, 32'h0200_0000);
    tick();
    check(phase_o == 32'h0400_0000, "R5", "advance after release", phase_o, 32'h0400_0000);
  endtask

  task automatic t_zero_ftw;
    logic [31:0] p;
    int e;
    write_reg(1'b0, 32'h0);
    pulse_update();
    p = phase_o;
    for (int i = 0; i < 4; i++) begin
      tick();
      check(phase_o == p, "R6", "zero step holds phase", phase_o, p);
    end
    e = exp_amp(p);
    check(int'(amp_o) - e >= -1 && int'(amp_o) - e <= 1, "R8", "amp at held phase", amp_o, e);
  endtask

  task automatic t_half;
    write_reg(1'b1, 32'h1);
    pulse_update();
    tick();
    write_reg(1'b0, 32'h8000_0000);
    write_reg(1'b1, 32'h0);
    pulse_update();
    check(phase_o == 0, "R7", "start at zero", phase_o, 0);
    tick();
    check(phase_o == 32'h8000_0000, "R5", "half step", phase_o, 32'h8000_0000);
    for (int k = 2; k < 8; k++) begin
      tick();
      check(amp_o == ((k % 2 == 0) ? 10'd1023 : 10'd1), "R9", "alternating extremes",
            amp_o, (k % 2 == 0) ? 1023 : 1);
    end
  endtask

  task automatic t_wrap;
    logic [31:0] exp_seq [4];
    exp_seq[0] = 32'hC000_0000; exp_seq[1] = 32'h8000_0000;
    exp_seq[2] = 32'h4000_0000; exp_seq[3] = 32'h0;
    write_reg(1'b1, 32'h1);
    pulse_update();
    write_reg(1'b0, 32'hC000_0000);
    write_reg(1'b1, 32'h0);
    pulse_update();
    check(phase_o == 0, "R7", "wrap start", phase_o, 0);
    for (int i = 0; i < 4; i++) begin
      tick();
      check(phase_o == exp_seq[i], "R5", "modulo wrap", phase_o, exp_seq[i]);
    end
  endtask

  task automatic t_coincident;
    logic [31:0] p, d;
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h1000_0000; update = 1'b1;
    tick();
    wr_en = 1'b0; update = 1'b0;
    p = phase_o; tick(); d = phase_o - p;
    check(d == 32'hC000_0000, "R4", "same-cycle write not taken by update", d, 32'hC000_0000);
    pulse_update();
    p = phase_o; tick(); d = phase_o - p;
    check(d == 32'h1000_0000, "R4", "later update takes new step", d, 32'h1000_0000);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_hold_after_reset();
    t_first_update();
    t_sweep();
    t_staging();
    t_clear();
    t_zero_ftw();
    t_half();
    t_wrap();
    t_coincident();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule